// File: doc/BRIEF.md
# AXI-Lite Data Width Down Converter

This block joins a wide AXI-Lite master port to a narrower AXI-Lite slave port. The narrow width divides the wide width: 64 to 32, 32 to 16 and 32 to 8 all work. A wide write is broken into narrow writes, one for each narrow lane whose strobe bits are not all zero. The narrow writes go out in ascending byte address order, starting from the lowest lane. A wide read is broken into one narrow read per lane, also lowest address first. The narrow read results are packed back into a single wide read beat.

The master sees one response per wide transaction. That response is given only after every narrow sub-transaction has finished. Its code is the most severe code the slave returned. The block handles one wide transaction at a time, and the narrow slave may take any number of cycles to accept a request or to respond.

Top module: `axil_dnconv`

## Requirements
- R1: Each narrow write targets the wide address with its low log2(wide bytes) bits cleared, plus lane index times narrow byte width. Narrow writes are issued in ascending lane order, lane 0 first.
- R2: Lane k of a narrow write carries wide data bits [k*NARROW_W +: NARROW_W]. Its strobe is the wide strobe slice [k*NB +: NB], copied unchanged, partial slices included.
- R3: A lane whose strobe slice is all zero produces no narrow write. A wide write whose strobe is entirely zero produces no narrow traffic at all and is answered with OKAY (code 0).
- R4: A wide read issues exactly WIDE_W/NARROW_W narrow reads at ascending lane addresses. The result from lane k lands in wide read data bits [k*NARROW_W +: NARROW_W].
- R5: The wide write or read response is given once, after all narrow responses of that transaction. Its code is the numeric maximum of the narrow codes (OKAY=0, EXOKAY=1, SLVERR=2, DECERR=3). A non-OKAY lane does not stop the remaining lanes from being issued.
- R6: Only one wide transaction is in flight at a time. When a write address with write data and a read address are both pending while idle, the write is accepted first.
- R7: A narrow request valid, once raised, stays high with its address and strobe stable until the slave accepts it.
- R8: After reset, every valid output on both sides is low.
- R9: The low address bits below the wide word size are ignored. A wide write to 0x23 with 16-bit lanes goes to 0x20 and 0x22.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_aw_valid | input | 1 | Wide write address valid |
| s_aw_ready | output | 1 | Wide write address accepted |
| s_aw_addr | input | ADDR_W | Wide write address |
| s_w_valid | input | 1 | Wide write data valid |
| s_w_ready | output | 1 | Wide write data accepted |
| s_w_data | input | WIDE_W | Wide write data |
| s_w_strb | input | WIDE_W/8 | Wide write byte strobes |
| s_b_valid | output | 1 | Wide write response valid |
| s_b_ready | input | 1 | Wide write response taken |
| s_b_resp | output | 2 | Wide write response code |
| s_ar_valid | input | 1 | Wide read address valid |
| s_ar_ready | output | 1 | Wide read address accepted |
| s_ar_addr | input | ADDR_W | Wide read address |
| s_r_valid | output | 1 | Wide read data valid |
| s_r_ready | input | 1 | Wide read data taken |
| s_r_data | output | WIDE_W | Assembled wide read data |
| s_r_resp | output | 2 | Wide read response code |
| m_aw_valid | output | 1 | Narrow write address valid |
| m_aw_ready | input | 1 | Narrow write address accepted |
| m_aw_addr | output | ADDR_W | Narrow write address |
| m_w_valid | output | 1 | Narrow write data valid |
| m_w_ready | input | 1 | Narrow write data accepted |
| m_w_data | output | NARROW_W | Narrow write data |
| m_w_strb | output | NARROW_W/8 | Narrow write strobes |
| m_b_valid | input | 1 | Narrow write response valid |
| m_b_ready | output | 1 | Narrow write response taken |
| m_b_resp | input | 2 | Narrow write response code |
| m_ar_valid | output | 1 | Narrow read address valid |
| m_ar_ready | input | 1 | Narrow read address accepted |
| m_ar_addr | output | ADDR_W | Narrow read address |
| m_r_valid | input | 1 | Narrow read data valid |
| m_r_ready | output | 1 | Narrow read data taken |
| m_r_data | input | NARROW_W | Narrow read data |
| m_r_resp | input | 2 | Narrow read response code |

## Verification
The hold properties assume that the wide master keeps its response ready signals well-behaved. They also assume the narrow slave answers only when the converter is waiting for a response, so `m_b_valid` and `m_r_valid` are never offered outside that phase. The bench slave model follows these rules. It raises response valid only after it has accepted a request. It adds a rotating 0 to 2 cycle delay before each accept. While it waits, it confirms that the request stays stable. The bench master raises write address and write data together and keeps each valid high until its ready arrives.

// File: rtl/dnconv_pkg.sv
package dnconv_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_ISSUE, PH_RESP, PH_DONE} phase_t;

  // Most severe of two response codes (higher code is worse)
  function automatic logic [1:0] resp_worse(input logic [1:0] a, input logic [1:0] b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/dnconv_lane_pick.sv
module dnconv_lane_pick #(
  parameter int LANES = 2,
  parameter int IW    = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [LANES-1:0] mask,
  input  logic [IW:0]      from,
  output logic             found,
  output logic [IW-1:0]    lane
);
  // Lowest active lane at or above 'from'
  always_comb begin
    found = 1'b0;
    lane  = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (mask[i] && (i >= int'(from))) begin
        found = 1'b1;
        lane  = IW'(i);
      end
    end
  end
endmodule

// File: rtl/dnconv_wr.sv
module dnconv_wr
  import dnconv_pkg::*;
#(
  parameter int AW = 32,
  parameter int WW = 32,
  parameter int NW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [AW-1:0]   addr_in,
  input  logic [WW-1:0]   data_in,
  input  logic [WW/8-1:0] strb_in,
  output logic            busy,
  output logic            m_aw_valid,
  input  logic            m_aw_ready,
  output logic [AW-1:0]   m_aw_addr,
  output logic            m_w_valid,
  input  logic            m_w_ready,
  output logic [NW-1:0]   m_w_data,
  output logic [NW/8-1:0] m_w_strb,
  input  logic            m_b_valid,
  output logic            m_b_ready,
  input  logic [1:0]      m_b_resp,
  output logic            s_b_valid,
  input  logic            s_b_ready,
  output logic [1:0]      s_b_resp
);
  localparam int LANES = WW / NW;
  localparam int NB    = NW / 8;
  localparam int WB    = WW / 8;
  localparam int IW    = (LANES > 1) ? $clog2(LANES) : 1;

  phase_t          phase_q;
  logic [AW-1:0]   base_q;
  logic [WW-1:0]   data_q;
  logic [WB-1:0]   strb_q;
  logic [IW-1:0]   lane_q;
  logic            aw_done_q, w_done_q;
  logic [1:0]      resp_q;

  logic [WB-1:0]    src_strb;
  logic [LANES-1:0] lane_hit;
  logic [IW:0]      pick_from;
  logic             pick_found;
  logic [IW-1:0]    pick_lane;
  logic             aw_hs, w_hs;

  assign src_strb  = (phase_q == PH_IDLE) ? strb_in : strb_q;
  assign pick_from = (phase_q == PH_IDLE) ? '0 : ({1'b0, lane_q} + 1'b1);

  for (genvar g = 0; g < LANES; g++) begin : g_hit
    assign lane_hit[g] = |src_strb[g*NB +: NB];
  end

  dnconv_lane_pick #(.LANES(LANES), .IW(IW)) u_pick (
    .mask (lane_hit),
    .from (pick_from),
    .found(pick_found),
    .lane (pick_lane)
  );

  assign aw_hs = m_aw_valid && m_aw_ready;
  assign w_hs  = m_w_valid && m_w_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_IDLE;
      base_q    <= '0;
      data_q    <= '0;
      strb_q    <= '0;
      lane_q    <= '0;
      aw_done_q <= 1'b0;
      w_done_q  <= 1'b0;
      resp_q    <= 2'd0;
    end else begin
      case (phase_q)
        PH_IDLE: if (start) begin
          base_q    <= addr_in & ~(AW'(WB - 1));
          data_q    <= data_in;
          strb_q    <= strb_in;
          resp_q    <= 2'd0;
          aw_done_q <= 1'b0;
          w_done_q  <= 1'b0;
          lane_q    <= pick_lane;
          phase_q   <= pick_found ? PH_ISSUE : PH_DONE;
        end
        PH_ISSUE: begin
          if (aw_hs) aw_done_q <= 1'b1;
          if (w_hs)  w_done_q  <= 1'b1;
          if ((aw_done_q || aw_hs) && (w_done_q || w_hs)) phase_q <= PH_RESP;
        end
        PH_RESP: if (m_b_valid) begin
          resp_q    <= resp_worse(resp_q, m_b_resp);
          aw_done_q <= 1'b0;
          w_done_q  <= 1'b0;
          lane_q    <= pick_lane;
          phase_q   <= pick_found ? PH_ISSUE : PH_DONE;
        end
        PH_DONE: if (s_b_ready) phase_q <= PH_IDLE;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign busy       = (phase_q != PH_IDLE);
  assign m_aw_valid = (phase_q == PH_ISSUE) && !aw_done_q;
  assign m_w_valid  = (phase_q == PH_ISSUE) && !w_done_q;
  assign m_aw_addr  = base_q + AW'(lane_q) * AW'(NB);
  assign m_w_data   = data_q[lane_q*NW +: NW];
  assign m_w_strb   = strb_q[lane_q*NB +: NB];
  assign m_b_ready  = (phase_q == PH_RESP);
  assign s_b_valid  = (phase_q == PH_DONE);
  assign s_b_resp   = resp_q;
endmodule

// File: rtl/dnconv_rd.sv
module dnconv_rd
  import dnconv_pkg::*;
#(
  parameter int AW = 32,
  parameter int WW = 32,
  parameter int NW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] addr_in,
  output logic          busy,
  output logic          m_ar_valid,
  input  logic          m_ar_ready,
  output logic [AW-1:0] m_ar_addr,
  input  logic          m_r_valid,
  output logic          m_r_ready,
  input  logic [NW-1:0] m_r_data,
  input  logic [1:0]    m_r_resp,
  output logic          s_r_valid,
  input  logic          s_r_ready,
  output logic [WW-1:0] s_r_data,
  output logic [1:0]    s_r_resp
);
  localparam int LANES = WW / NW;
  localparam int NB    = NW / 8;
  localparam int WB    = WW / 8;
  localparam int IW    = (LANES > 1) ? $clog2(LANES) : 1;

  phase_t        phase_q;
  logic [AW-1:0] base_q;
  logic [IW-1:0] lane_q;
  logic [WW-1:0] acc_q;
  logic [1:0]    resp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      base_q  <= '0;
      lane_q  <= '0;
      acc_q   <= '0;
      resp_q  <= 2'd0;
    end else begin
      case (phase_q)
        PH_IDLE: if (start) begin
          base_q  <= addr_in & ~(AW'(WB - 1));
          lane_q  <= '0;
          resp_q  <= 2'd0;
          phase_q <= PH_ISSUE;
        end
        PH_ISSUE: if (m_ar_ready) phase_q <= PH_RESP;
        PH_RESP: if (m_r_valid) begin
          acc_q[lane_q*NW +: NW] <= m_r_data;
          resp_q <= resp_worse(resp_q, m_r_resp);
          if (lane_q == IW'(LANES - 1)) begin
            phase_q <= PH_DONE;
          end else begin
            lane_q  <= lane_q + 1'b1;
            phase_q <= PH_ISSUE;
          end
        end
        PH_DONE: if (s_r_ready) phase_q <= PH_IDLE;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign busy       = (phase_q != PH_IDLE);
  assign m_ar_valid = (phase_q == PH_ISSUE);
  assign m_ar_addr  = base_q + AW'(lane_q) * AW'(NB);
  assign m_r_ready  = (phase_q == PH_RESP);
  assign s_r_valid  = (phase_q == PH_DONE);
  assign s_r_data   = acc_q;
  assign s_r_resp   = resp_q;
endmodule

// File: rtl/axil_dnconv.sv
module axil_dnconv #(
  parameter int ADDR_W   = 32,
  parameter int WIDE_W   = 32,
  parameter int NARROW_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  s_aw_valid,
  output logic                  s_aw_ready,
  input  logic [ADDR_W-1:0]     s_aw_addr,
  input  logic                  s_w_valid,
  output logic                  s_w_ready,
  input  logic [WIDE_W-1:0]     s_w_data,
  input  logic [WIDE_W/8-1:0]   s_w_strb,
  output logic                  s_b_valid,
  input  logic                  s_b_ready,
  output logic [1:0]            s_b_resp,
  input  logic                  s_ar_valid,
  output logic                  s_ar_ready,
  input  logic [ADDR_W-1:0]     s_ar_addr,
  output logic                  s_r_valid,
  input  logic                  s_r_ready,
  output logic [WIDE_W-1:0]     s_r_data,
  output logic [1:0]            s_r_resp,
  output logic                  m_aw_valid,
  input  logic                  m_aw_ready,
  output logic [ADDR_W-1:0]     m_aw_addr,
  output logic                  m_w_valid,
  input  logic                  m_w_ready,
  output logic [NARROW_W-1:0]   m_w_data,
  output logic [NARROW_W/8-1:0] m_w_strb,
  input  logic                  m_b_valid,
  output logic                  m_b_ready,
  input  logic [1:0]            m_b_resp,
  output logic                  m_ar_valid,
  input  logic                  m_ar_ready,
  output logic [ADDR_W-1:0]     m_ar_addr,
  input  logic                  m_r_valid,
  output logic                  m_r_ready,
  input  logic [NARROW_W-1:0]   m_r_data,
  input  logic [1:0]            m_r_resp
);
  logic wr_busy, rd_busy, idle, wr_go, rd_go;

  // One transaction at a time; a complete write request wins over a read
  assign idle  = !wr_busy && !rd_busy;
  assign wr_go = idle && s_aw_valid && s_w_valid;
  assign rd_go = idle && s_ar_valid && !(s_aw_valid && s_w_valid);

  assign s_aw_ready = wr_go;
  assign s_w_ready  = wr_go;
  assign s_ar_ready = rd_go;

  dnconv_wr #(.AW(ADDR_W), .WW(WIDE_W), .NW(NARROW_W)) u_wr (
    .clk(clk), .rst(rst), .start(wr_go),
    .addr_in(s_aw_addr), .data_in(s_w_data), .strb_in(s_w_strb), .busy(wr_busy),
    .m_aw_valid(m_aw_valid), .m_aw_ready(m_aw_ready), .m_aw_addr(m_aw_addr),
    .m_w_valid(m_w_valid), .m_w_ready(m_w_ready), .m_w_data(m_w_data), .m_w_strb(m_w_strb),
    .m_b_valid(m_b_valid), .m_b_ready(m_b_ready), .m_b_resp(m_b_resp),
    .s_b_valid(s_b_valid), .s_b_ready(s_b_ready), .s_b_resp(s_b_resp)
  );

  dnconv_rd #(.AW(ADDR_W), .WW(WIDE_W), .NW(NARROW_W)) u_rd (
    .clk(clk), .rst(rst), .start(rd_go), .addr_in(s_ar_addr), .busy(rd_busy),
    .m_ar_valid(m_ar_valid), .m_ar_ready(m_ar_ready), .m_ar_addr(m_ar_addr),
    .m_r_valid(m_r_valid), .m_r_ready(m_r_ready), .m_r_data(m_r_data), .m_r_resp(m_r_resp),
    .s_r_valid(s_r_valid), .s_r_ready(s_r_ready), .s_r_data(s_r_data), .s_r_resp(s_r_resp)
  );
endmodule

// File: rtl/dnconv_chk.sv
module dnconv_chk #(
  parameter int ADDR_W   = 32,
  parameter int WIDE_W   = 32,
  parameter int NARROW_W = 16
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  m_aw_valid,
  input logic                  m_aw_ready,
  input logic [ADDR_W-1:0]     m_aw_addr,
  input logic                  m_w_valid,
  input logic                  m_w_ready,
  input logic [NARROW_W/8-1:0] m_w_strb,
  input logic                  m_ar_valid,
  input logic                  m_ar_ready,
  input logic [ADDR_W-1:0]     m_ar_addr,
  input logic                  s_b_valid,
  input logic                  s_b_ready,
  input logic [1:0]            s_b_resp,
  input logic                  s_r_valid,
  input logic                  s_r_ready,
  input logic [WIDE_W-1:0]     s_r_data
);
  localparam int NB = NARROW_W / 8;

  assert_aw_hold_R7: assert property (@(posedge clk) disable iff (rst)
    m_aw_valid && !m_aw_ready |=> m_aw_valid && $stable(m_aw_addr));
  assert_w_hold_R7: assert property (@(posedge clk) disable iff (rst)
    m_w_valid && !m_w_ready |=> m_w_valid && $stable(m_w_strb));
  assert_ar_hold_R7: assert property (@(posedge clk) disable iff (rst)
    m_ar_valid && !m_ar_ready |=> m_ar_valid && $stable(m_ar_addr));
  assert_nonzero_strb_R3: assert property (@(posedge clk) disable iff (rst)
    m_w_valid |-> (m_w_strb != '0));
  assert_lane_align_R1: assert property (@(posedge clk) disable iff (rst)
    m_aw_valid |-> ((m_aw_addr % ADDR_W'(NB)) == '0));
  assert_single_req_R6: assert property (@(posedge clk) disable iff (rst)
    (m_aw_valid || m_w_valid) |-> !m_ar_valid);
  assert_single_resp_R6: assert property (@(posedge clk) disable iff (rst)
    !(s_b_valid && s_r_valid));
  assert_bresp_hold_R5: assert property (@(posedge clk) disable iff (rst)
    s_b_valid && !s_b_ready |=> s_b_valid && $stable(s_b_resp));
  assert_rdata_hold_R4: assert property (@(posedge clk) disable iff (rst)
    s_r_valid && !s_r_ready |=> s_r_valid && $stable(s_r_data));
endmodule

bind axil_dnconv dnconv_chk #(.ADDR_W(ADDR_W), .WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_chk (.*);

// File: tb/test_axil_dnconv.sv
module test_axil_dnconv;
  localparam int AW = 32, WW = 32, NW = 16, LANES = WW / NW, NB = NW / 8, WB = WW / 8;

  logic clk = 1'b0, rst = 1'b1;
  always #5 clk = ~clk;

  logic s_aw_valid = 0, s_w_valid = 0, s_b_ready = 0, s_ar_valid = 0, s_r_ready = 0;
  logic [AW-1:0] s_aw_addr = '0, s_ar_addr = '0;
  logic [WW-1:0] s_w_data = '0;
  logic [WB-1:0] s_w_strb = '0;
  logic s_aw_ready, s_w_ready, s_b_valid, s_ar_ready, s_r_valid;
  logic [1:0] s_b_resp, s_r_resp;
  logic [WW-1:0] s_r_data;
  logic m_aw_valid, m_w_valid, m_b_ready, m_ar_valid, m_r_ready;
  logic [AW-1:0] m_aw_addr, m_ar_addr;
  logic [NW-1:0] m_w_data;
  logic [NB-1:0] m_w_strb;
  logic m_aw_ready = 0, m_w_ready = 0, m_b_valid = 0, m_ar_ready = 0, m_r_valid = 0;
  logic [1:0] m_b_resp = 0, m_r_resp = 0;
  logic [NW-1:0] m_r_data = '0;

  axil_dnconv #(.ADDR_W(AW), .WIDE_W(WW), .NARROW_W(NW)) i_axil_dnconv (.*);

  int n_chk = 0, n_bad = 0;
  logic [7:0] bmem [0:1023];
  logic [7:0] emem [0:1023];
  logic [AW-1:0] log_addr [0:7];
  logic [NW-1:0] log_data [0:7];
  logic [NB-1:0] log_strb [0:7];
  int log_n = 0;
  logic [AW-1:0] rlog_addr [0:7];
  int rlog_n = 0;
  logic [AW-1:0] err_waddr = 32'hFFFF_FFFF, err_raddr = 32'hFFFF_FFFF;
  int first_op = 0;
  int lat_w = 0, lat_r = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  // Narrow write slave with rotating accept latency
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && m_aw_valid && m_w_valid) begin
        logic [AW-1:0] a0;
        a0 = m_aw_addr;
        repeat (lat_w) @(negedge clk);
        lat_w = (lat_w + 1) % 3;
        chk("R7 write request held", {31'd0, m_aw_valid, m_aw_addr}, {31'd0, 1'b1, a0});
        m_aw_ready = 1; m_w_ready = 1;
        if (first_op == 0) first_op = 1;
        log_addr[log_n] = m_aw_addr; log_data[log_n] = m_w_data; log_strb[log_n] = m_w_strb;
        log_n++;
        for (int b = 0; b < NB; b++)
          if (m_w_strb[b]) bmem[(m_aw_addr + b) % 1024] = m_w_data[b*8 +: 8];
        @(posedge clk); #1;
        m_aw_ready = 0; m_w_ready = 0;
        m_b_valid = 1; m_b_resp = (a0 == err_waddr) ? 2'd2 : 2'd0;
        @(negedge clk);
        while (!m_b_ready) @(negedge clk);
        @(posedge clk); #1;
        m_b_valid = 0;
      end
    end
  end

  // Narrow read slave
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && m_ar_valid) begin
        logic [AW-1:0] a0;
        a0 = m_ar_addr;
        repeat (lat_r) @(negedge clk);
        lat_r = (lat_r + 1) % 3;
        m_ar_ready = 1;
        if (first_op == 0) first_op = 2;
        rlog_addr[rlog_n] = a0; rlog_n++;
        @(posedge clk); #1;
        m_ar_ready = 0;
        m_r_valid = 1; m_r_resp = (a0 == err_raddr) ? 2'd3 : 2'd0;
        for (int b = 0; b < NB; b++) m_r_data[b*8 +: 8] = bmem[(a0 + b) % 1024];
        @(negedge clk);
        while (!m_r_ready) @(negedge clk);
        @(posedge clk); #1;
        m_r_valid = 0;
      end
    end
  end

  task automatic wide_write(input logic [AW-1:0] a, input logic [WW-1:0] d,
                            input logic [WB-1:0] s, output logic [1:0] resp);
    @(negedge clk);
    s_aw_addr = a; s_w_data = d; s_w_strb = s; s_aw_valid = 1; s_w_valid = 1;
    #1;
    while (!s_aw_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    s_aw_valid = 0; s_w_valid = 0; s_b_ready = 1;
    @(negedge clk);
    while (!s_b_valid) @(negedge clk);
    resp = s_b_resp;
    @(posedge clk); #1;
    s_b_ready = 0;
    for (int b = 0; b < WB; b++)
      if (s[b]) emem[((a & ~32'(WB - 1)) + b) % 1024] = d[b*8 +: 8];
  endtask

  task automatic wide_read(input logic [AW-1:0] a, output logic [WW-1:0] d, output logic [1:0] resp);
    @(negedge clk);
    s_ar_addr = a; s_ar_valid = 1;
    #1;
    while (!s_ar_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    s_ar_valid = 0; s_r_ready = 1;
    @(negedge clk);
    while (!s_r_valid) @(negedge clk);
    d = s_r_data; resp = s_r_resp;
    @(posedge clk); #1;
    s_r_ready = 0;
  endtask

  // Vector: {address, data, strobe}
  localparam int NV = 6;
  localparam logic [67:0] VEC [0:NV-1] = '{
    {32'h0000_0000, 32'h2222_1111, 4'hF},
    {32'h0000_0004, 32'h4444_3333, 4'hF},
    {32'h0000_0008, 32'h6666_5555, 4'hB},
    {32'h0000_0100, 32'h8888_7777, 4'h3},
    {32'h0000_010C, 32'hAAAA_9999, 4'hC},
    {32'h0000_0044, 32'hCCCC_BBBB, 4'h4}
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    report();
  end

  initial begin
    logic [1:0] resp, rresp, wresp2;
    logic [WW-1:0] rd, exp;
    logic [AW-1:0] a, al;
    logic [WW-1:0] d;
    logic [WB-1:0] s;
    int k;
    for (int i = 0; i < 1024; i++) begin bmem[i] = 8'(i * 7 + 3); emem[i] = 8'(i * 7 + 3); end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 reset valids", {m_aw_valid, m_w_valid, m_ar_valid, s_b_valid, s_r_valid}, 5'b0);
    rst = 0;
    @(negedge clk);
    chk("R8 idle after reset", {m_aw_valid, m_ar_valid, s_b_valid, s_r_valid}, 4'b0);

    // Table of writes, then read back
    for (int v = 0; v < NV; v++) begin
      a = VEC[v][67:36]; d = VEC[v][35:4]; s = VEC[v][3:0];
      log_n = 0;
      wide_write(a, d, s, resp);
      al = a & ~32'(WB - 1);
      k = 0;
      for (int l = 0; l < LANES; l++) begin
        if (s[l*NB +: NB] != '0) begin
          if (k < log_n) begin
            chk("R1 narrow write address order", log_addr[k], al + l * NB);
            chk("R2 narrow write data", log_data[k], d[l*NW +: NW]);
            chk("R2 narrow write strobe", log_strb[k], s[l*NB +: NB]);
          end
          k++;
        end
      end
      chk("R3 narrow write count", log_n, k);
      chk("R5 write response", resp, 2'd0);
    end
    for (int v = 0; v < NV; v++) begin
      a = VEC[v][67:36]; al = a & ~32'(WB - 1);
      rlog_n = 0;
      wide_read(a, rd, resp);
      for (int b = 0; b < WB; b++) exp[b*8 +: 8] = emem[(al + b) % 1024];
      chk("R4 assembled read data", rd, exp);
      chk("R4 narrow read count", rlog_n, LANES);
      chk("R4 read lane 0 address", rlog_addr[0], al);
      chk("R4 read lane 1 address", rlog_addr[1], al + NB);
      chk("R5 read response", resp, 2'd0);
    end

    // Whole strobe zero: no narrow traffic, OKAY
    log_n = 0;
    wide_write(32'h80, 32'hDEAD_BEEF, 4'h0, resp);
    chk("R3 zero strobe no traffic", log_n, 0);
    chk("R3 zero strobe response", resp, 2'd0);
    wide_read(32'h80, rd, resp);
    exp = {emem[131], emem[130], emem[129], emem[128]};
    chk("R3 zero strobe memory untouched", rd, exp);

    // Unaligned wide address
    log_n = 0;
    wide_write(32'h23, 32'h1357_2468, 4'hF, resp);
    chk("R9 unaligned count", log_n, 2);
    chk("R9 lane 0 address", log_addr[0], 32'h20);
    chk("R9 lane 1 address", log_addr[1], 32'h22);

    // Slave error on one lane
    log_n = 0; err_waddr = 32'h202;
    wide_write(32'h200, 32'h0F0F_F0F0, 4'hF, resp);
    chk("R5 write worst response", resp, 2'd2);
    chk("R5 later lanes still issued", log_n, 2);
    err_waddr = 32'hFFFF_FFFF; err_raddr = 32'h200;
    wide_read(32'h200, rd, resp);
    chk("R5 read worst response", resp, 2'd3);
    chk("R5 read data despite error", rd, 32'h0F0F_F0F0);
    err_raddr = 32'hFFFF_FFFF;

    // Write and read pending together: write first
    first_op = 0;
    fork
      wide_write(32'h300, 32'hA1B2_C3D4, 4'hF, wresp2);
      wide_read(32'h300, rd, rresp);
    join
    chk("R6 write wins arbitration", first_op, 1);
    chk("R6 read sees prior write", rd, 32'hA1B2_C3D4);
    chk("R6 write response", wresp2, 2'd0);

    repeat (4) @(negedge clk);
    report();
  end
endmodule